// File: doc/BRIEF.md
# Unanimity-Filtered Input Synchronizer

This block carries a single asynchronous level into one clock domain. The level is shifted through a chain of flip-flops. A registered hysteresis decision then sets the output only when every chain stage reads one, and clears it only when every stage reads zero. Any other mix leaves the output where it was. The chain therefore resolves metastability and also rejects short glitches, acting as a crude low-pass filter.

The number of chain stages is a parameter. A second parameter slows the chain: with `SAMPLE_DIV` greater than one, the stages shift only on one clock in every `SAMPLE_DIV`. Each stage then has a full slow period to settle, and the glitch-rejection window is stretched by the same factor. The output register is clocked on every clock, so it follows the chain on the clock edge after the chain becomes unanimous.

Top module: `unan_sync`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every chain stage, the output and the divider phase to zero. After reset is released, a high input cannot reach the output before the chain has been refilled.
- R2: `dout` changes from 0 to 1 only on a clock edge at which all chain stages held 1 just before the edge.
- R3: `dout` changes from 1 to 0 only on a clock edge at which all chain stages held 0 just before the edge.
- R4: When the chain holds a mix of ones and zeros, `dout` keeps its previous value.
- R5: With `SAMPLE_DIV` = 1, an input pulse lasting fewer than `STAGES` clocks never changes `dout`.
- R6: With `SAMPLE_DIV` = 1, a level change that is present before clock edge k and then held appears on `dout` at edge k + `STAGES`, which is `STAGES` + 1 edges counting edge k.
- R7: With `SAMPLE_DIV` = D > 1, the chain shifts only on every D-th clock edge after reset. The first shift happens on edge D after reset is released. `dout` is re-evaluated on every edge.
- R8: With `SAMPLE_DIV` = D, a pulse that lasts `STAGES`−1 sample periods (D·(`STAGES`−1) clocks) never changes `dout`. This holds for any chain depth, including four stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Destination-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Asynchronous input level |
| dout | output | 1 | Filtered, synchronized level (registered) |

## Verification
The hardest state to reach is a chain that is one stage short of unanimous, followed by a reversal. That is the only situation that separates a correct hold from an early set or clear. It requires pulse widths sitting exactly at the rejection boundary, and when the chain is slowed they must also line up with the divider phase. The stimulus therefore combines directed pulses of exactly `STAGES`−1 sample periods with long runs of random pulse widths on two instances, one fast three-stage chain and one divided four-stage chain. Each instance is followed cycle by cycle by a model derived from the requirements.

// File: rtl/unan_sync.sv
module unan_sync #(
  parameter int STAGES     = 3,
  parameter int SAMPLE_DIV = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;

  logic [STAGES-1:0] chain;
  logic              tick;
  logic              all_hi, all_lo;

  generate
    if (SAMPLE_DIV > 1) begin : g_div
      logic [CW-1:0] phase;
      always_ff @(posedge clk) begin
        if (rst)                                  phase <= '0;
        else if (phase == CW'(SAMPLE_DIV - 1))    phase <= '0;
        else                                      phase <= phase + 1'b1;
      end
      assign tick = (phase == CW'(SAMPLE_DIV - 1));
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       chain <= '0;
    else if (tick) chain <= {chain[STAGES-2:0], din};
  end

  assign all_hi = &chain;
  assign all_lo = ~|chain;

  always_ff @(posedge clk) begin
    if (rst)         dout <= 1'b0;
    else if (all_hi) dout <= 1'b1;
    else if (all_lo) dout <= 1'b0;
  end

  logic started;
  always_ff @(posedge clk) started <= rst ? 1'b1 : started;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!started)
    rst |=> (dout == 1'b0 && chain == '0));
  // R2
  rise_unanimous_chk: assert property (@(posedge clk) disable iff (rst || !started)
    $rose(dout) |-> $past(&chain));
  // R3
  fall_unanimous_chk: assert property (@(posedge clk) disable iff (rst || !started)
    $fell(dout) |-> $past(~|chain));
  // R4
  mixed_hold_chk: assert property (@(posedge clk) disable iff (rst || !started)
    ((|chain) && !(&chain)) |=> $stable(dout));
  // R7
  chain_idle_chk: assert property (@(posedge clk) disable iff (rst || !started)
    !tick |=> $stable(chain));
endmodule

// File: tb/unan_sync_tb.sv
module unan_sync_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SA = 3, DA = 1;
  localparam int SB = 4, DB = 4;

  logic clk = 0, rst = 1, din = 0;
  logic dout_a, dout_b;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  unan_sync #(.STAGES(SA), .SAMPLE_DIV(DA)) dut_i
    (.clk(clk), .rst(rst), .din(din), .dout(dout_a));
  unan_sync #(.STAGES(SB), .SAMPLE_DIV(DB)) dut_div_i
    (.clk(clk), .rst(rst), .din(din), .dout(dout_b));

  logic [SA-1:0] ca; logic ea; string ta;
  logic [SB-1:0] cb; logic eb; string tb; int kb;

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic decide(input logic allh, input logic alll, input logic cur);
    return allh ? 1'b1 : (alll ? 1'b0 : cur);
  endfunction

  function automatic string tag_of(input logic prev, input logic nxt);
    if (!prev && nxt) return "R2";
    if (prev && !nxt) return "R3";
    return "R4";
  endfunction

  task automatic cyc(input logic v, input logic r = 1'b0);
    logic na, nb;
    @(negedge clk);
    check(dout_a, ea, ta);
    check(dout_b, eb, tb);
    din = v; rst = r;
    if (r) begin
      ca = '0; ea = 0; cb = '0; eb = 0; kb = 0; ta = "R1"; tb = "R1";
    end else begin
      na = decide(&ca, ~|ca, ea); ta = tag_of(ea, na); ea = na;
      ca = {ca[SA-2:0], v};
      nb = decide(&cb, ~|cb, eb); tb = tag_of(eb, nb); eb = nb;
      if (kb == DB-1) begin cb = {cb[SB-2:0], v}; tb = {tb, "/R7"}; end
      kb = (kb + 1) % DB;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, w;
    logic lvl;
    ca = '0; ea = 0; cb = '0; eb = 0; kb = 0; ta = "R1"; tb = "R1";
    void'($urandom(32'h5EED_0017));
    cyc(1, 1); cyc(1, 1);
    // R1: outputs zero after reset, and a high input must refill the chain
    @(negedge clk);
    check(dout_a, 1'b0, "R1 reset a"); check(dout_b, 1'b0, "R1 reset b");
    for (int i = 0; i < SA; i++) cyc(1);
    check(dout_a, 1'b0, "R1 refill a");
    for (int i = 0; i < 30; i++) cyc(0);

    // R6: latency of a held rising level, fast chain
    cyc(1); n = 0;
    for (int i = 0; i < 10; i++) begin
      cyc(1); n++;
      if (dout_a) break;
    end
    check(n == SA + 1, 1'b1, "R6 rise latency");
    for (int i = 0; i < 30; i++) cyc(1);
    // R6: falling latency
    cyc(0); n = 0;
    for (int i = 0; i < 10; i++) begin
      cyc(0); n++;
      if (!dout_a) break;
    end
    check(n == SA + 1, 1'b1, "R6 fall latency");
    for (int i = 0; i < 30; i++) cyc(0);

    // R5: pulse of STAGES-1 clocks on the fast chain
    for (int i = 0; i < SA - 1; i++) cyc(1);
    for (int i = 0; i < 10; i++) begin
      cyc(0); check(dout_a, 1'b0, "R5 short high pulse");
    end
    for (int i = 0; i < 30; i++) cyc(1);
    for (int i = 0; i < SA - 1; i++) cyc(0);
    for (int i = 0; i < 10; i++) begin
      cyc(1); check(dout_a, 1'b1, "R5 short low pulse");
    end
    for (int i = 0; i < 40; i++) cyc(0);

    // R8: pulse of (SB-1) sample periods on the divided four-stage chain
    for (int p = 0; p < DB; p++) begin
      for (int i = 0; i < p; i++) cyc(0);
      for (int i = 0; i < DB * (SB - 1); i++) cyc(1);
      for (int i = 0; i < DB * (SB + 2); i++) begin
        cyc(0); check(dout_b, 1'b0, "R8 divided short pulse");
      end
    end
    // R7: a long level reaches the divided output
    for (int i = 0; i < DB * (SB + 2); i++) cyc(1);
    check(dout_b, 1'b1, "R7 divided long level");
    for (int i = 0; i < DB * (SB + 2); i++) cyc(0);
    check(dout_b, 1'b0, "R7 divided long low");

    // Random pulse widths against the model (R2 R3 R4 R7)
    lvl = 0;
    for (int k = 0; k < 1500; k++) begin
      lvl = ~lvl;
      w = 1 + ($urandom % 22);
      for (int i = 0; i < w; i++) cyc(lvl);
    end
    // R1: reset in the middle of traffic
    for (int i = 0; i < 40; i++) cyc(1);
    cyc(1, 1);
    @(negedge clk);
    check(dout_a, 1'b0, "R1 mid reset a"); check(dout_b, 1'b0, "R1 mid reset b");
    for (int i = 0; i < 40; i++) cyc(1);
    check(dout_a, 1'b1, "R1 after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule